// File: doc/BRIEF.md
# Alarm Comparator With Repeat Modes

This block watches a running calendar time given in BCD (seconds, minutes, hours, day of month, month) and raises an alarm when that time matches a programmed alarm setting. The repeat bits stored in the top bits of the alarm bytes select how many of the time fields take part in the match. This gives an alarm once per second, minute, hour, day or month. Once per month uses all five fields.

The compare runs only on the cycle in which the one-per-second `tick` strobe is high, so each second can set the alarm flag at most once. A match sets the alarm flag `af`. It also pulls the active-low interrupt `irq_n` low when the interrupt enable is set. While `in_backup` is high, the interrupt also needs the backup alarm enable. Software clears the alarm with two pulses of `flag_rd`. The first pulse releases the interrupt pin and a later pulse clears `af`.

The alarm bytes are written and read through a plain byte register port. The read data is combinational from `rd_addr`. The block has no streaming data path, so every pin is a plain control or status signal, and there is no valid/ready handshake and no back-pressure.

Top module: `alarm_cmp`

## Requirements
- R1: After reset, `af` is 0, `irq_n` is 1 and every register address reads 0. This means both enables are cleared.
- R2: The register addresses are 0 = seconds, 1 = minutes, 2 = hours, 3 = date and 4 = month/enables. A write to addresses 0 to 4 is read back unchanged. Addresses 5 to 7 ignore writes and read 0.
- R3: The repeat code {P4,P3,P2,P1} is taken from bit 7 of addresses 3, 2, 1 and 0. The codes are:
  - 1111 matches on every tick.
  - 1110 compares seconds.
  - 1100 compares minutes and seconds.
  - 1000 compares hours, minutes and seconds.
  - 0000 compares all five fields.
- R4: Any other repeat code behaves like 1111 and matches on every tick.
- R5: A match is evaluated only in a cycle with `tick` high. Only these bits are compared:
  - seconds and minutes: bits 6:0
  - hours and date: bits 5:0
  - month: bits 4:0
- R6: On a match, `af` is 1 from the next cycle. `irq_n` goes low in the same cycle when the interrupt enable (address 4 bit 7) is 1 and `in_backup` is 0.
- R7: While `in_backup` is 1, a match sets `af` but drives `irq_n` low only when both the interrupt enable and the backup enable (address 4 bit 6) are 1.
- R8: A `flag_rd` pulse while `irq_n` is low releases `irq_n` and leaves `af` set. A `flag_rd` pulse while `irq_n` is high clears `af`.
- R9: With repeat code 0000 and an alarm date field (bits 5:0) of zero, the alarm never matches.
- R10: A match in the same cycle as `flag_rd` leaves `af` set.
- R11: Bit 6 of address 3 is stored and read back, but has no effect on matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also the power-up clear |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| flag_rd | input | 1 | Flag read strobe, one cycle per read |
| tick | input | 1 | One-per-second compare strobe |
| t_sec | input | 8 | Current seconds, BCD |
| t_min | input | 8 | Current minutes, BCD |
| t_hour | input | 8 | Current hours, BCD |
| t_date | input | 8 | Current day of month, BCD |
| t_month | input | 8 | Current month, BCD |
| in_backup | input | 1 | High while running on backup power |
| af | output | 1 | Alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions assume the following about the inputs:
- `tick` and `flag_rd` are synchronous to `clk`.
- The time fields and `in_backup` are stable across the cycle in which `tick` is high, so the state of `af` and `irq_n` depends only on what was sampled at that edge.

The stimulus drives every input on the falling edge, holds `tick` and `flag_rd` high for exactly one cycle, and changes the alarm bytes only while `tick` is low. All five fields are held at a known matching value, and each case moves exactly one of them, so the expected match for every repeat code follows from the number of fields that code compares.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

  localparam int BYTE_W      = 8;
  localparam int N_FLD       = 5;
  localparam int F_SEC       = 0;
  localparam int F_MIN       = 1;
  localparam int F_HOUR      = 2;
  localparam int F_DATE      = 3;
  localparam int F_MON       = 4;
  localparam int RPT_BIT     = 7;
  localparam int IRQ_EN_BIT  = 7;
  localparam int BKUP_EN_BIT = 6;

  typedef logic [N_FLD-1:0][BYTE_W-1:0] fld_bank_t;

  typedef enum logic [2:0] {
    MODE_SEC,
    MODE_MIN,
    MODE_HOUR,
    MODE_DAY,
    MODE_MONTH
  } rpt_mode_e;

  // Repeat code is {P4,P3,P2,P1}; unlisted codes fall back to every tick.
  function automatic rpt_mode_e decode_rpt(input logic [3:0] code);
    case (code)
      4'b1111: return MODE_SEC;
      4'b1110: return MODE_MIN;
      4'b1100: return MODE_HOUR;
      4'b1000: return MODE_DAY;
      4'b0000: return MODE_MONTH;
      default: return MODE_SEC;
    endcase
  endfunction

  // Number of fields, counted from seconds upward, that take part in a match.
  function automatic int unsigned cmp_depth(input rpt_mode_e m);
    case (m)
      MODE_SEC:   return 0;
      MODE_MIN:   return 1;
      MODE_HOUR:  return 2;
      MODE_DAY:   return 3;
      MODE_MONTH: return N_FLD;
      default:    return 0;
    endcase
  endfunction

  // Significant BCD bits of each field; the rest hold flags.
  function automatic logic [BYTE_W-1:0] fld_mask(input int unsigned f);
    case (f)
      F_SEC:   return 8'h7F;
      F_MIN:   return 8'h7F;
      F_HOUR:  return 8'h3F;
      F_DATE:  return 8'h3F;
      F_MON:   return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/alarm_cmp_regs.sv
module alarm_cmp_regs
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output fld_bank_t         alm
);

  localparam int N_ADDR = 1 << ADDR_W;

  fld_bank_t bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_FLD; i++) begin
        if (wr_addr == ADDR_W'(i)) bank_q[i] <= wr_data;
      end
    end
  end

  // Addresses above the last field decode to nothing and read as zero.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_FLD && i < N_ADDR; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = bank_q[i];
    end
  end

  assign alm = bank_q;

endmodule

// File: rtl/alarm_cmp_match.sv
module alarm_cmp_match
  import alarm_cmp_pkg::*;
(
  input  fld_bank_t alm,
  input  fld_bank_t now,
  output logic      hit
);

  logic [3:0]  code;
  rpt_mode_e   mode;
  int unsigned depth;
  logic        disabled;
  logic [N_FLD-1:0] fld_eq;
  logic [N_FLD-1:0] fld_ok;

  assign code = {alm[F_DATE][RPT_BIT], alm[F_HOUR][RPT_BIT],
                 alm[F_MIN][RPT_BIT],  alm[F_SEC][RPT_BIT]};

  always_comb begin
    mode  = decode_rpt(code);
    depth = cmp_depth(mode);
  end

  // Monthly mode with a zero date can never match a real date; treat it as off.
  assign disabled = (code == 4'b0000) &&
                    ((alm[F_DATE] & fld_mask(F_DATE)) == '0);

  for (genvar g = 0; g < N_FLD; g++) begin : g_fld
    assign fld_eq[g] = (((alm[g] ^ now[g]) & fld_mask(g)) == '0);
    assign fld_ok[g] = fld_eq[g] || (depth <= g);
  end

  assign hit = (&fld_ok) && !disabled;

endmodule

// File: rtl/alarm_cmp_flags.sv
module alarm_cmp_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic flag_rd,
  input  logic irq_en,
  input  logic bkup_en,
  input  logic in_backup,
  output logic af,
  output logic irq_pend
);

  logic af_d;
  logic pend_d;
  logic set_af;
  logic set_irq;

  assign set_af  = tick && hit;
  assign set_irq = set_af && irq_en && (!in_backup || bkup_en);

  // A flag read first drops the pin; only with the pin released does it clear
  // the flag. A new match in the same cycle wins over either clear.
  always_comb begin
    af_d   = af;
    pend_d = irq_pend;
    if (flag_rd) begin
      if (irq_pend) pend_d = 1'b0;
      else          af_d   = 1'b0;
    end
    if (set_af)  af_d   = 1'b1;
    if (set_irq) pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      af       <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      af       <= af_d;
      irq_pend <= pend_d;
    end
  end

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              flag_rd,
  input  logic              tick,
  input  logic [BYTE_W-1:0] t_sec,
  input  logic [BYTE_W-1:0] t_min,
  input  logic [BYTE_W-1:0] t_hour,
  input  logic [BYTE_W-1:0] t_date,
  input  logic [BYTE_W-1:0] t_month,
  input  logic              in_backup,
  output logic              af,
  output logic              irq_n
);

  fld_bank_t alm;
  fld_bank_t now;
  logic      hit;
  logic      irq_en;
  logic      bkup_en;
  logic      irq_pend;

  assign now = {t_month, t_date, t_hour, t_min, t_sec};

  alarm_cmp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .alm     (alm)
  );

  assign irq_en  = alm[F_MON][IRQ_EN_BIT];
  assign bkup_en = alm[F_MON][BKUP_EN_BIT];

  alarm_cmp_match u_match (
    .alm (alm),
    .now (now),
    .hit (hit)
  );

  alarm_cmp_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hit       (hit),
    .flag_rd   (flag_rd),
    .irq_en    (irq_en),
    .bkup_en   (bkup_en),
    .in_backup (in_backup),
    .af        (af),
    .irq_pend  (irq_pend)
  );

  assign irq_n = !irq_pend;

endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic flag_rd,
  input logic in_backup,
  input logic hit,
  input logic irq_en,
  input logic bkup_en,
  input logic af,
  input logic irq_n
);

  AST_AF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af) |-> $past(tick)); // R5

  AST_QUIET_HOLDS_AF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flag_rd) |=> $stable(af)); // R5

  AST_HIT_SETS_AF: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit) |=> af); // R6

  AST_HIT_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit && irq_en && !in_backup) |=> !irq_n); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(irq_en)); // R6

  AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_n) && $past(in_backup)) |-> $past(bkup_en)); // R7

  AST_IRQ_IMPLIES_AF: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> af); // R8

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !irq_n && !tick) |=> irq_n); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit && flag_rd) |=> af); // R10

endmodule

bind alarm_cmp alarm_cmp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .flag_rd   (flag_rd),
  .in_backup (in_backup),
  .hit       (hit),
  .irq_en    (irq_en),
  .bkup_en   (bkup_en),
  .af        (af),
  .irq_n     (irq_n)
);

// File: tb/tb_alarm_cmp.sv
module tb_alarm_cmp;

  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0]        rd_data;
  logic              flag_rd = 1'b0;
  logic              tick = 1'b0;
  logic [7:0]        t_sec = '0, t_min = '0, t_hour = '0, t_date = '0, t_month = '0;
  logic              in_backup = 1'b0;
  logic              af;
  logic              irq_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  alarm_cmp #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flag_rd(flag_rd), .tick(tick),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_date(t_date), .t_month(t_month),
    .in_backup(in_backup), .af(af), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic set_alarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] mo);
    wr(0, s); wr(1, m); wr(2, h); wr(3, d); wr(4, mo);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] d, input logic [7:0] mo);
    @(negedge clk);
    t_sec = s; t_min = m; t_hour = h; t_date = d; t_month = mo;
  endtask

  // One tick cycle, optionally with a flag read in the same cycle; sampled after the edge.
  task automatic pulse(input bit do_tick, input bit do_rd);
    @(negedge clk);
    tick = do_tick; flag_rd = do_rd;
    @(negedge clk);
    tick = 1'b0; flag_rd = 1'b0;
  endtask

  task automatic clear_flags();
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
  endtask

  function automatic int depth_of(input int code);
    case (code)
      15: return 0;
      14: return 1;
      12: return 2;
      8:  return 3;
      0:  return 5;
      default: return 0;
    endcase
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] base [5];
    logic [7:0] alt  [5];
    base[0] = 8'h45; base[1] = 8'h30; base[2] = 8'h12; base[3] = 8'h15; base[4] = 8'h07;
    alt[0]  = 8'h46; alt[1]  = 8'h31; alt[2]  = 8'h13; alt[3]  = 8'h16; alt[4]  = 8'h08;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 af", {7'd0, af}, 8'd0);
    chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
    for (int a = 0; a < 8; a++) rd_chk("R1 regs", a, 8'h00);

    // R2: readback and unmapped addresses
    set_alarm(8'hA5, 8'h5A, 8'h3C, 8'hC3, 8'h0F);
    wr(5, 8'hFF); wr(6, 8'hEE); wr(7, 8'hDD);
    rd_chk("R2 sec", 0, 8'hA5);
    rd_chk("R2 min", 1, 8'h5A);
    rd_chk("R2 hour", 2, 8'h3C);
    rd_chk("R2 date", 3, 8'hC3);
    rd_chk("R2 month", 4, 8'h0F);
    for (int a = 5; a < 8; a++) rd_chk("R2 unmapped", a, 8'h00);

    // R3/R4/R6: every repeat code against one moved field at a time
    for (int code = 0; code < 16; code++) begin
      for (int v = 0; v < 6; v++) begin
        logic [7:0] tv [5];
        bit exp_hit;
        string tag;
        set_alarm({code[0], base[0][6:0]}, {code[1], base[1][6:0]}, {code[2], base[2][6:0]},
                  {code[3], base[3][6:0]}, 8'h80 | base[4]);
        clear_flags();
        for (int f = 0; f < 5; f++) tv[f] = (v == f + 1) ? alt[f] : base[f];
        set_time(tv[0], tv[1], tv[2], tv[3], tv[4]);
        exp_hit = (v == 0) || ((v - 1) >= depth_of(code));
        tag = (code == 15 || code == 14 || code == 12 || code == 8 || code == 0) ? "R3" : "R4";
        pulse(1'b1, 1'b0);
        chk($sformatf("%s code=%0h moved=%0d af", tag, code, v), {7'd0, af}, {7'd0, exp_hit});
        chk($sformatf("R6 code=%0h moved=%0d irq_n", code, v), {7'd0, irq_n}, {7'd0, !exp_hit});
      end
    end

    // R5: no tick, no set
    set_alarm(8'h45, 8'h30, 8'h12, 8'h15, 8'h87);
    clear_flags();
    set_time(8'h45, 8'h30, 8'h12, 8'h15, 8'h07);
    repeat (4) @(negedge clk);
    chk("R5 no tick af", {7'd0, af}, 8'd0);
    chk("R5 no tick irq_n", {7'd0, irq_n}, 8'd1);

    // R5: flag bits of the time inputs are outside the compare masks
    set_time(8'hC5, 8'hB0, 8'hD2, 8'hD5, 8'hE7);
    pulse(1'b1, 1'b0);
    chk("R5 masked bits af", {7'd0, af}, 8'd1);
    clear_flags();

    // R8: two-step clear
    set_time(8'h45, 8'h30, 8'h12, 8'h15, 8'h07);
    pulse(1'b1, 1'b0);
    chk("R8 set af", {7'd0, af}, 8'd1);
    chk("R8 set irq_n", {7'd0, irq_n}, 8'd0);
    pulse(1'b0, 1'b1);
    chk("R8 first read irq_n", {7'd0, irq_n}, 8'd1);
    chk("R8 first read af", {7'd0, af}, 8'd1);
    pulse(1'b0, 1'b1);
    chk("R8 second read af", {7'd0, af}, 8'd0);

    // R7: backup power gating
    in_backup = 1'b1;
    set_alarm(8'hC5, 8'h30, 8'h12, 8'h95, 8'h87);
    clear_flags();
    pulse(1'b1, 1'b0);
    chk("R7 backup no bkup_en af", {7'd0, af}, 8'd1);
    chk("R7 backup no bkup_en irq_n", {7'd0, irq_n}, 8'd1);
    wr(4, 8'hC7);
    clear_flags();
    pulse(1'b1, 1'b0);
    chk("R7 backup both irq_n", {7'd0, irq_n}, 8'd0);
    wr(4, 8'h47);
    clear_flags();
    pulse(1'b1, 1'b0);
    chk("R7 backup only bkup_en irq_n", {7'd0, irq_n}, 8'd1);
    in_backup = 1'b0;
    clear_flags();

    // R9: monthly code with zero date is off
    set_alarm(8'h45, 8'h30, 8'h12, 8'h00, 8'h87);
    set_time(8'h45, 8'h30, 8'h12, 8'h00, 8'h07);
    clear_flags();
    pulse(1'b1, 1'b0);
    chk("R9 disabled af", {7'd0, af}, 8'd0);
    chk("R9 disabled irq_n", {7'd0, irq_n}, 8'd1);
    wr(3, 8'h01);
    set_time(8'h45, 8'h30, 8'h12, 8'h01, 8'h07);
    pulse(1'b1, 1'b0);
    chk("R9 nonzero date af", {7'd0, af}, 8'd1);
    clear_flags();

    // R11: date bit 6 does not change monthly matching
    set_alarm(8'h45, 8'h30, 8'h12, 8'h55, 8'h07);
    rd_chk("R11 readback", 3, 8'h55);
    set_time(8'h45, 8'h30, 8'h12, 8'h15, 8'h07);
    clear_flags();
    pulse(1'b1, 1'b0);
    chk("R11 full match af", {7'd0, af}, 8'd1);
    clear_flags();
    set_time(8'h45, 8'h30, 8'h12, 8'h16, 8'h07);
    pulse(1'b1, 1'b0);
    chk("R11 date differs af", {7'd0, af}, 8'd0);

    // R10: set beats a same-cycle read
    set_time(8'h45, 8'h30, 8'h12, 8'h15, 8'h07);
    clear_flags();
    pulse(1'b1, 1'b1);
    chk("R10 set with read from clear", {7'd0, af}, 8'd1);
    pulse(1'b1, 1'b1);
    chk("R10 set with read from set", {7'd0, af}, 8'd1);
    pulse(1'b0, 1'b1);
    chk("R10 read alone clears", {7'd0, af}, 8'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule